// File: doc/BRIEF.md
# Power Path Source Arbiter

This block decides, from sampled voltage codes, how a portable device takes its power. It watches four digital codes: the USB input rail, the system output rail, the battery and the sense pin of an external adapter. From them it decides whether the input-to-output switch may close, whether an adapter counts as present (reported on an active-low flag), whether the charger may run, and which input current-limit scale applies. A suspend request and a high-power select come in as plain logic levels.

Every threshold decision passes through a qualifier with hysteresis and then through a glitch filter. A qualifier changes state only after the condition that would flip it has held for `FILT_LEN` consecutive samples. Adapter detection needs two rising conditions at once, and either of two falling conditions releases it. Two reverse-current lockouts, each with its own hysteresis, guard the input path and the charger. All codes are unsigned with one LSB per millivolt. The outputs are registered, so an output follows a qualifier change one clock later.

Top module: `pp_src_arbiter`

## Requirements
- R1: A qualifier changes state only after its flipping condition has been true on FILT_LEN (default 4) consecutive clocks. A shorter run restarts the count, and a qualified change reaches the outputs on the following clock.
- R2: The adapter becomes present only when its code is above 4250 and also above battery + 75. Meeting either condition alone detects nothing.
- R3: A present adapter is released when its code drops below 3120, or when it drops below battery + 25. Between these points it stays present.
- R4: While the adapter is present, path_en_o is 0 and adp_n_o is 0.
- R5: The input path is locked out once output > input. The lockout clears only when input >= output + 50.
- R6: Each of input, output and battery has an undervoltage qualifier with 125 mV of hysteresis. It becomes ok at code >= level (input 3800, output 3600, battery 2600) and drops when the code is < level - 125. path_en_o needs input ok.
- R7: The charger is locked out once battery > output. The lockout clears only when output >= battery + 50.
- R8: chg_en_o is 1 exactly when the output is ok and the charger lockout is clear. susp_i has no effect on it.
- R9: susp_i = 1 forces path_en_o to 0 on the next clock.
- R10: ilim_full_o follows hpwr_i one clock later: 1 selects the 100% scale, 0 the 20% scale.
- R11: adp_n_o is held at 1 whenever no supply (input, output, battery) is ok, even when the adapter qualifier is set.
- R12: Synchronous active-low reset gives path_en_o=0, adp_n_o=1, chg_en_o=0, ilim_full_o=0. Both reverse lockouts start engaged and the other qualifiers start clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vin_code_i | input | VW | Input rail code, mV |
| vout_code_i | input | VW | Output rail code, mV |
| vbat_code_i | input | VW | Battery code, mV |
| vadp_code_i | input | VW | Adapter sense code, mV |
| susp_i | input | 1 | Suspend request |
| hpwr_i | input | 1 | High-power select |
| path_en_o | output | 1 | Input-to-output switch enable |
| adp_n_o | output | 1 | Adapter present, active low |
| chg_en_o | output | 1 | Charger enable |
| ilim_full_o | output | 1 | Current-limit scale: 1 = 100%, 0 = 20% |

## Verification
The hardest state to reach is an adapter that is qualified while every supply is still in lockout. Only then can the flag suppression of R11 be seen, because the adapter qualifier is set but no supply is ok. The stimulus gets there by driving all supply codes to zero and holding a high adapter code against a zero battery code. It also drives the adapter code into the band between release and detect, and puts the battery code within 75 mV of the adapter. Each of these separates the two rising conditions and the two falling conditions from one another. A long randomized phase then moves the codes back and forth across every threshold, with hold times around FILT_LEN, while a behavioural model is compared on every clock.

// File: rtl/pp_arb_pkg.sv
// Package: shared indices, reset vector and condition type for the source arbiter.
// Assumes six qualifiers in a fixed order that every module indexes the same way.
package pp_arb_pkg;
    localparam int NQ        = 6;
    localparam int QI_IN_UV  = 0;
    localparam int QI_OUT_UV = 1;
    localparam int QI_BAT_UV = 2;
    localparam int QI_IN_REV = 3;
    localparam int QI_CHG_REV = 4;
    localparam int QI_ADP    = 5;
    localparam int N_UV      = 3;

    // Reverse lockouts start engaged; everything else starts clear.
    localparam logic [NQ-1:0] QUAL_RST = 6'b011000;

    typedef struct packed {
        logic set;
        logic clr;
    } qcond_t;
endpackage

// File: rtl/pp_qual_filter.sv
// Module: one hysteretic qualifier with a consecutive-sample glitch filter.
// What it does: the state flips after the condition that opposes it
// (set while clear, clr while set) has held for FILT_LEN clocks in a row.
// Assumes set and clr are never both true.
module pp_qual_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic state_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          state_q;
    logic [CW-1:0] cnt_q;
    logic          want;

    // Select the condition that would move the present state.
    always_comb begin
        want = state_q ? clr_i : set_i;
    end

    // Count consecutive qualifying samples and flip on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_VAL;
            cnt_q   <= '0;
        end else if (want) begin
            if (cnt_q == LAST) begin
                state_q <= ~state_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/pp_thresh_decode.sv
// Module: combinational threshold decode for all six qualifiers.
// What it does: turns the raw codes into set/clear conditions with
// hysteresis. Assumes codes are unsigned, 1 LSB per mV; sums are widened.
module pp_thresh_decode
    import pp_arb_pkg::*;
#(
    parameter int VW                = 13,
    parameter int IN_UV_MV          = 3800,
    parameter int OUT_UV_MV         = 3600,
    parameter int BAT_UV_MV         = 2600,
    parameter int UV_HYS_MV         = 125,
    parameter int REV_HYS_MV        = 50,
    parameter int ADP_ON_MV         = 4250,
    parameter int ADP_OFF_MV        = 3120,
    parameter int ADP_ON_MARGIN_MV  = 75,
    parameter int ADP_OFF_MARGIN_MV = 25
) (
    input  logic [VW-1:0]     vin_i,
    input  logic [VW-1:0]     vout_i,
    input  logic [VW-1:0]     vbat_i,
    input  logic [VW-1:0]     vadp_i,
    output qcond_t [NQ-1:0]   cond_o
);
    localparam int XW = VW + 1;
    localparam int UV_LEVEL [N_UV] = '{IN_UV_MV, OUT_UV_MV, BAT_UV_MV};
    localparam logic [VW-1:0] ADP_ON  = VW'(ADP_ON_MV);
    localparam logic [VW-1:0] ADP_OFF = VW'(ADP_OFF_MV);

    logic [VW-1:0] uv_code [N_UV];
    logic [XW-1:0] vin_x, vout_x, vbat_x, vadp_x;
    logic [XW-1:0] vout_rev, vbat_rev, vbat_on, vbat_off;

    // Gather the supply codes in qualifier order.
    always_comb begin
        uv_code[QI_IN_UV]  = vin_i;
        uv_code[QI_OUT_UV] = vout_i;
        uv_code[QI_BAT_UV] = vbat_i;
    end

    // Undervoltage qualifiers: rise at the level, fall below level minus hysteresis.
    generate
        for (genvar g = 0; g < N_UV; g++) begin : g_uv
            localparam logic [VW-1:0] RISE = VW'(UV_LEVEL[g]);
            localparam logic [VW-1:0] FALL = VW'(UV_LEVEL[g] - UV_HYS_MV);
            assign cond_o[g].set = (uv_code[g] >= RISE);
            assign cond_o[g].clr = (uv_code[g] <  FALL);
        end
    endgenerate

    // Widened copies and offset sums for the difference comparisons.
    always_comb begin
        vin_x    = {1'b0, vin_i};
        vout_x   = {1'b0, vout_i};
        vbat_x   = {1'b0, vbat_i};
        vadp_x   = {1'b0, vadp_i};
        vout_rev = vout_x + XW'(REV_HYS_MV);
        vbat_rev = vbat_x + XW'(REV_HYS_MV);
        vbat_on  = vbat_x + XW'(ADP_ON_MARGIN_MV);
        vbat_off = vbat_x + XW'(ADP_OFF_MARGIN_MV);
    end

    // Reverse-current lockouts and the two-condition adapter detector.
    always_comb begin
        cond_o[QI_IN_REV].set  = (vout_x > vin_x);
        cond_o[QI_IN_REV].clr  = (vin_x >= vout_rev);
        cond_o[QI_CHG_REV].set = (vbat_x > vout_x);
        cond_o[QI_CHG_REV].clr = (vout_x >= vbat_rev);
        cond_o[QI_ADP].set     = (vadp_i > ADP_ON) && (vadp_x > vbat_on);
        cond_o[QI_ADP].clr     = (vadp_i < ADP_OFF) || (vadp_x < vbat_off);
    end
endmodule

// File: rtl/pp_src_decide.sv
// Module: output decision stage.
// What it does: combines the qualified states with suspend and high-power
// select into registered outputs. Assumes states come from the filter bank.
module pp_src_decide
    import pp_arb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] qual_st_i,
    input  logic          susp_i,
    input  logic          hpwr_i,
    output logic          path_en_o,
    output logic          adp_n_o,
    output logic          chg_en_o,
    output logic          ilim_full_o
);
    logic supply_any;
    logic adp_valid;
    logic path_next;
    logic chg_next;

    // Combine qualified states into next-output values.
    always_comb begin
        supply_any = qual_st_i[QI_IN_UV] | qual_st_i[QI_OUT_UV] | qual_st_i[QI_BAT_UV];
        adp_valid  = qual_st_i[QI_ADP] & supply_any;
        path_next  = qual_st_i[QI_IN_UV] & ~qual_st_i[QI_IN_REV]
                   & ~qual_st_i[QI_ADP] & ~susp_i;
        chg_next   = qual_st_i[QI_OUT_UV] & ~qual_st_i[QI_CHG_REV];
    end

    // Register the outputs with their safe reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_en_o   <= 1'b0;
            adp_n_o     <= 1'b1;
            chg_en_o    <= 1'b0;
            ilim_full_o <= 1'b0;
        end else begin
            path_en_o   <= path_next;
            adp_n_o     <= ~adp_valid;
            chg_en_o    <= chg_next;
            ilim_full_o <= hpwr_i;
        end
    end
endmodule

// File: rtl/pp_src_arbiter.sv
// Module: power path source arbiter, top level.
// What it does: decodes thresholds, filters every qualifier and drives the
// path, adapter flag, charger enable and current-limit scale.
// Assumes codes are sampled synchronously to clk.
module pp_src_arbiter
    import pp_arb_pkg::*;
#(
    parameter int VW                = 13,
    parameter int FILT_LEN          = 4,
    parameter int IN_UV_MV          = 3800,
    parameter int OUT_UV_MV         = 3600,
    parameter int BAT_UV_MV         = 2600,
    parameter int UV_HYS_MV         = 125,
    parameter int REV_HYS_MV        = 50,
    parameter int ADP_ON_MV         = 4250,
    parameter int ADP_OFF_MV        = 3120,
    parameter int ADP_ON_MARGIN_MV  = 75,
    parameter int ADP_OFF_MARGIN_MV = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vin_code_i,
    input  logic [VW-1:0] vout_code_i,
    input  logic [VW-1:0] vbat_code_i,
    input  logic [VW-1:0] vadp_code_i,
    input  logic          susp_i,
    input  logic          hpwr_i,
    output logic          path_en_o,
    output logic          adp_n_o,
    output logic          chg_en_o,
    output logic          ilim_full_o
);
    qcond_t [NQ-1:0] cond;
    logic   [NQ-1:0] qual_st;

    pp_thresh_decode #(
        .VW(VW), .IN_UV_MV(IN_UV_MV), .OUT_UV_MV(OUT_UV_MV), .BAT_UV_MV(BAT_UV_MV),
        .UV_HYS_MV(UV_HYS_MV), .REV_HYS_MV(REV_HYS_MV), .ADP_ON_MV(ADP_ON_MV),
        .ADP_OFF_MV(ADP_OFF_MV), .ADP_ON_MARGIN_MV(ADP_ON_MARGIN_MV),
        .ADP_OFF_MARGIN_MV(ADP_OFF_MARGIN_MV)
    ) decode_i (
        .vin_i (vin_code_i),
        .vout_i(vout_code_i),
        .vbat_i(vbat_code_i),
        .vadp_i(vadp_code_i),
        .cond_o(cond)
    );

    // One filtered qualifier per threshold event.
    generate
        for (genvar q = 0; q < NQ; q++) begin : g_qual
            pp_qual_filter #(
                .FILT_LEN(FILT_LEN),
                .RST_VAL (QUAL_RST[q])
            ) filt_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (cond[q].set),
                .clr_i  (cond[q].clr),
                .state_o(qual_st[q])
            );
        end
    endgenerate

    pp_src_decide decide_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual_st_i  (qual_st),
        .susp_i     (susp_i),
        .hpwr_i     (hpwr_i),
        .path_en_o  (path_en_o),
        .adp_n_o    (adp_n_o),
        .chg_en_o   (chg_en_o),
        .ilim_full_o(ilim_full_o)
    );
endmodule

// File: rtl/pp_src_arbiter_chk.sv
// Module: assertion checker bound to the source arbiter.
// Assumes it sees the top's ports and the qualified state vector.
module pp_src_arbiter_chk
    import pp_arb_pkg::*;
#(
    parameter int VW               = 13,
    parameter int FILT_LEN         = 4,
    parameter int ADP_ON_MV        = 4250,
    parameter int ADP_ON_MARGIN_MV = 75
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] vbat_code_i,
    input logic [VW-1:0] vadp_code_i,
    input logic          susp_i,
    input logic          hpwr_i,
    input logic          path_en_o,
    input logic          adp_n_o,
    input logic          ilim_full_o,
    input logic [NQ-1:0] qual_st
);
    localparam int RW = $clog2(FILT_LEN + 2);

    logic          adp_rise_cond;
    logic [RW-1:0] adp_run_q;

    // Independent view of the adapter detect condition from the ports.
    always_comb begin
        adp_rise_cond = (int'(vadp_code_i) > ADP_ON_MV)
                     && (int'(vadp_code_i) > int'(vbat_code_i) + ADP_ON_MARGIN_MV);
    end

    // Saturating run length of consecutive detect samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            adp_run_q <= '0;
        else if (!adp_rise_cond)
            adp_run_q <= '0;
        else if (adp_run_q != RW'(FILT_LEN))
            adp_run_q <= adp_run_q + 1'b1;
    end

    AST_ADP_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_st[QI_ADP]) |-> (adp_run_q == RW'(FILT_LEN))); // R1

    AST_ADP_BLOCKS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !adp_n_o |-> !path_en_o); // R4

    AST_SUSP_BLOCKS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        susp_i |=> !path_en_o); // R9

    AST_ILIM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hpwr_i |=> ilim_full_o); // R10

    AST_ILIM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !hpwr_i |=> !ilim_full_o); // R10

    AST_FLAG_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adp_n_o) |-> $past(qual_st[QI_IN_UV] | qual_st[QI_OUT_UV] | qual_st[QI_BAT_UV])); // R11
endmodule

bind pp_src_arbiter pp_src_arbiter_chk #(
    .VW(VW), .FILT_LEN(FILT_LEN), .ADP_ON_MV(ADP_ON_MV), .ADP_ON_MARGIN_MV(ADP_ON_MARGIN_MV)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbat_code_i(vbat_code_i),
    .vadp_code_i(vadp_code_i),
    .susp_i     (susp_i),
    .hpwr_i     (hpwr_i),
    .path_en_o  (path_en_o),
    .adp_n_o    (adp_n_o),
    .ilim_full_o(ilim_full_o),
    .qual_st    (qual_st)
);

// File: tb/pp_src_arbiter_tb.sv
module pp_src_arbiter_tb_top;
    localparam int CLK_P = 10;
    localparam int VW    = 13;
    localparam int NF    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vin = '0, vout = '0, vbat = '0, vadp = '0;
    logic          susp = 1'b0, hpwr = 1'b0;
    logic          path_en, adp_n, chg_en, ilim_full;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R12";
    bit    started = 0;

    always #(CLK_P/2) clk = ~clk;

    pp_src_arbiter #(.VW(VW), .FILT_LEN(NF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vin_code_i(vin), .vout_code_i(vout), .vbat_code_i(vbat), .vadp_code_i(vadp),
        .susp_i(susp), .hpwr_i(hpwr),
        .path_en_o(path_en), .adp_n_o(adp_n), .chg_en_o(chg_en), .ilim_full_o(ilim_full)
    );

    // Behavioural reference: six hysteretic flags with run counters.
    int mst [6];
    int mcnt[6];
    bit mset[6];
    bit mclr[6];
    bit m_path = 0, m_adpn = 1, m_chg = 0, m_ilim = 0;
    int vi, vo, vb, va;

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin
                mst[i]  = (i == 3 || i == 4) ? 1 : 0;
                mcnt[i] = 0;
            end
            m_path = 0; m_adpn = 1; m_chg = 0; m_ilim = 0;
        end else begin
            m_path = (mst[0] == 1) && (mst[3] == 0) && (mst[5] == 0) && !susp;
            m_adpn = !((mst[5] == 1) && (mst[0] + mst[1] + mst[2] > 0));
            m_chg  = (mst[1] == 1) && (mst[4] == 0);
            m_ilim = hpwr;
            vi = int'(vin); vo = int'(vout); vb = int'(vbat); va = int'(vadp);
            mset[0] = vi >= 3800; mclr[0] = vi < 3675;
            mset[1] = vo >= 3600; mclr[1] = vo < 3475;
            mset[2] = vb >= 2600; mclr[2] = vb < 2475;
            mset[3] = vo > vi;    mclr[3] = vi >= vo + 50;
            mset[4] = vb > vo;    mclr[4] = vo >= vb + 50;
            mset[5] = (va > 4250) && (va > vb + 75);
            mclr[5] = (va < 3120) || (va < vb + 25);
            for (int i = 0; i < 6; i++) begin
                if ((mst[i] == 1) ? mclr[i] : mset[i]) begin
                    if (mcnt[i] == NF - 1) begin
                        mst[i]  = 1 - mst[i];
                        mcnt[i] = 0;
                    end else begin
                        mcnt[i]++;
                    end
                end else begin
                    mcnt[i] = 0;
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "path_en", path_en, m_path);
            chk(cur_req, "adp_n", adp_n, m_adpn);
            chk(cur_req, "chg_en", chg_en, m_chg);
            chk(cur_req, "ilim_full", ilim_full, m_ilim);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R12: reset values.
        step(3);
        chk("R12", "rst path_en", path_en, 1'b0);
        chk("R12", "rst adp_n", adp_n, 1'b1);
        chk("R12", "rst chg_en", chg_en, 1'b0);
        chk("R12", "rst ilim", ilim_full, 1'b0);
        rst_n = 1'b1;

        // R6/R8: power up from the input.
        cur_req = "R6";
        vin = 5000; vout = 4900; vbat = 3700; hpwr = 1;
        step(8);
        chk("R6", "path on", path_en, 1'b1);
        chk("R8", "chg on", chg_en, 1'b1);
        chk("R10", "ilim full", ilim_full, 1'b1);

        cur_req = "R10";
        hpwr = 0; step(1);
        chk("R10", "ilim low", ilim_full, 1'b0);

        // R9/R8: suspend closes the path, charger untouched.
        cur_req = "R9";
        susp = 1; step(1);
        chk("R9", "susp path", path_en, 1'b0);
        chk("R8", "susp chg", chg_en, 1'b1);
        susp = 0; step(2);

        // R1: glitch one sample short of the filter length.
        cur_req = "R1";
        vadp = 4600; step(NF - 1);
        vadp = 0; step(8);
        chk("R1", "glitch ignored", adp_n, 1'b1);
        chk("R1", "glitch path", path_en, 1'b1);

        // R2/R4: sustained adapter.
        cur_req = "R4";
        vadp = 4600; step(8);
        chk("R4", "adp flag", adp_n, 1'b0);
        chk("R4", "adp path", path_en, 1'b0);
        vadp = 0; step(8);

        // R2: voltage high but too close to battery.
        cur_req = "R2";
        vbat = 4240; vadp = 4300; step(8);
        chk("R2", "margin short", adp_n, 1'b1);
        vbat = 3700; vadp = 4200; step(8);
        chk("R2", "level short", adp_n, 1'b1);

        // R3: release band and both release conditions.
        cur_req = "R3";
        vadp = 4600; step(8);
        vadp = 4000; step(8);
        chk("R3", "band holds", adp_n, 1'b0);
        vadp = 3500; step(8);
        chk("R3", "near battery release", adp_n, 1'b1);
        vbat = 2700; vadp = 4600; step(8);
        vadp = 3100; step(8);
        chk("R3", "low level release", adp_n, 1'b1);
        vbat = 3700; vadp = 0; step(4);

        // R5: input reverse lockout and its hysteresis.
        cur_req = "R5";
        vout = 5050; step(8);
        chk("R5", "rev lock", path_en, 1'b0);
        vout = 4980; step(8);
        chk("R5", "rev hold", path_en, 1'b0);
        vout = 4940; step(8);
        chk("R5", "rev release", path_en, 1'b1);

        // R6: input undervoltage hysteresis.
        cur_req = "R6";
        vbat = 3000; vin = 3700; vout = 3600; step(8);
        chk("R6", "above fall", path_en, 1'b1);
        vin = 3650; step(8);
        chk("R6", "below fall", path_en, 1'b0);
        vin = 3750; step(8);
        chk("R6", "below rise", path_en, 1'b0);
        vin = 3800; step(8);
        chk("R6", "at rise", path_en, 1'b1);

        // R7: charger reverse lockout.
        cur_req = "R7";
        vin = 5000; vout = 4500; step(8);
        vbat = 4520; step(8);
        chk("R7", "chg lock", chg_en, 1'b0);
        vbat = 4470; step(8);
        chk("R7", "chg hold", chg_en, 1'b0);
        vbat = 4440; step(8);
        chk("R7", "chg release", chg_en, 1'b1);

        // R11: adapter qualified but no supply ok.
        cur_req = "R11";
        vin = 0; vout = 0; vbat = 0; vadp = 4600; step(12);
        chk("R11", "no supply flag", adp_n, 1'b1);
        vbat = 3700; step(8);
        chk("R11", "battery ok flag", adp_n, 1'b0);

        // R1: randomized codes around every threshold.
        cur_req = "R1";
        for (int k = 0; k < 3000; k++) begin
            case ($urandom_range(0, 5))
                0: vin  = VW'($urandom_range(3550, 5100));
                1: vout = VW'($urandom_range(3400, 5100));
                2: vbat = VW'($urandom_range(2400, 4300));
                3: vadp = VW'($urandom_range(3000, 4700));
                4: susp = 1'($urandom_range(0, 1));
                default: hpwr = 1'($urandom_range(0, 1));
            endcase
            step($urandom_range(1, NF + 2));
        end

        // R12: reset mid-run.
        cur_req = "R12";
        rst_n = 1'b0; step(2);
        chk("R12", "re-rst path", path_en, 1'b0);
        chk("R12", "re-rst adp", adp_n, 1'b1);
        finish_run();
    end
endmodule